// File: doc/BRIEF.md
# Configurable Logic Slice

This block models one programmable logic slice. It holds two 4-input lookup tables, a 2:1 combining multiplexer and two output stages. Each output stage can be a register or a plain wire. Each table keeps sixteen content bits and a two-bit mode field. In one mode the table is a fixed truth table. In another it is a 16x1 memory the user can write. In a third it is a 16-bit shift register with a selectable tap. A fourth mode leaves the table unconfigured.

All configuration is held in volatile flops that form a single serial chain. A synchronous reset clears every bit of that chain, so the slice does nothing until a frame is loaded. To load a frame, raise `cfg_en` and shift the frame in on `cfg_din`, most significant bit first. While `cfg_en` is high, user writes, shifts and output register updates are all suspended.

A merge bit joins the two tables into a single 5-input function. The fifth input, `x5`, then chooses between the two tables. Both tables are addressed by `a_sel` in this case.

Top module: `cfg_slice`

## Requirements
- R1: On a synchronous reset (`rst_n` low at a rising edge), every configuration bit is cleared. Both table modes become 00 (unconfigured). An unconfigured table drives 0, so both outputs read 0 for every address until a frame is loaded.
- R2: The frame is 39 bits long and is shifted in MSB first, one bit per rising edge while `cfg_en`=1. The fields are: bit 38 merge, bit 37 register B, bit 36 register A, bits 35:34 mode B, bits 33:18 table B, bits 17:16 mode A, bits 15:0 table A. In each table field, the address value k selects content bit k.
- R3: Mode 01 is logic mode. The table output is content bit [address], with the address taken from `a_sel` or `b_sel`. The write inputs `a_we`/`a_wd` (and the B pair) have no effect on the content.
- R4: Mode 10 is memory mode. When `cfg_en`=0 and the write enable is 1, a rising edge stores the data bit at the addressed location. Reads are asynchronous.
- R5: Mode 11 is shift mode. When `cfg_en`=0 and the write enable is 1, a rising edge shifts the content up by one place and loads the data bit into bit 0. The address selects which tap drives the output.
- R6: When the merge bit is 1, table B is addressed by `a_sel`. The A path then carries table A's output when `x5`=0 and table B's output when `x5`=1. Together these realise any function of the five inputs {x5, a_sel}.
- R7: When an output's register bit is 1, the output is a flop. The flop loads the path value on each rising edge where `cfg_en`=0, so it lags the path by one cycle. When the register bit is 0, the output follows the path combinationally.
- R8: While `cfg_en`=1, asserting a write enable does not alter table content. After the load, the content equals the loaded frame exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| a_sel | input | 4 | Address of table A (and of table B when merged) |
| b_sel | input | 4 | Address of table B when not merged |
| x5 | input | 1 | Fifth input used when merged |
| a_we | input | 1 | Write/shift enable for table A |
| a_wd | input | 1 | Write/shift data for table A |
| b_we | input | 1 | Write/shift enable for table B |
| b_wd | input | 1 | Write/shift data for table B |
| out_a | output | 1 | Output A (merged function when merged) |
| out_b | output | 1 | Output B |

## Verification
The assertions assume the following about the inputs:
- Write enables, addresses and data are stable around each rising edge.
- The table mode does not change except through a configuration shift.
- The register-latency check holds only while `reg_sel` does not flip between the loading edge and the next one.

The stimulus respects all of this. Every input is changed on the falling edge. Register bits change only through full frame loads. Each sweep keeps one frame in place for its whole duration.

// File: rtl/slice_pkg.sv
// Shared types and frame layout constants for the logic slice.
// Assumes 2-bit mode fields and a 3-bit slice control field.
package slice_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_LOGIC = 2'b01,
        MODE_RAM   = 2'b10,
        MODE_SHIFT = 2'b11
    } lut_mode_e;

    localparam int MODE_W     = 2;
    localparam int CTRL_W     = 3;
    localparam int CTRL_REG_A = 0;
    localparam int CTRL_REG_B = 1;
    localparam int CTRL_MERGE = 2;
endpackage

// File: rtl/slice_lut.sv
// One lookup table with its mode field, held in a serial configuration chain.
// The chain shifts while cfg_en is high. Otherwise the mode decides whether
// we/wd write one bit, shift the content, or are ignored.
// Assumes addr, we and wd are stable around the rising edge.
module slice_lut
    import slice_pkg::*;
#(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_in,
    output logic         cfg_out,
    input  logic [K-1:0] addr,
    input  logic         we,
    input  logic         wd,
    output logic         dout
);
    localparam int DEPTH = 1 << K;
    localparam int CFG_W = DEPTH + MODE_W;

    logic [CFG_W-1:0] chain_q;
    logic [DEPTH-1:0] store;
    lut_mode_e        mode;

    assign store   = chain_q[DEPTH-1:0];
    assign mode    = lut_mode_e'(chain_q[CFG_W-1 -: MODE_W]);
    assign cfg_out = chain_q[CFG_W-1];

    // Configuration shift, memory write or content shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (cfg_en) begin
            chain_q <= {chain_q[CFG_W-2:0], cfg_in};
        end else if (we) begin
            case (mode)
                MODE_RAM:   chain_q[addr] <= wd;
                MODE_SHIFT: chain_q[DEPTH-1:0] <= {store[DEPTH-2:0], wd};
                default:    ;
            endcase
        end
    end

    // Asynchronous read; an unconfigured table drives zero.
    always_comb begin
        dout = (mode == MODE_OFF) ? 1'b0 : store[addr];
    end

    // Logic mode content is untouched by user writes.
    p_logic_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && mode == MODE_LOGIC) |=> $stable(store));

    // Memory mode stores the data bit at the address.
    p_ram_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && we && mode == MODE_RAM) |=> store[$past(addr)] == $past(wd));

    // Shift mode moves content up and inserts data at bit 0.
    p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && we && mode == MODE_SHIFT) |=>
            (store[0] == $past(wd) && store[DEPTH-1:1] == $past(store[DEPTH-2:0])));
endmodule

// File: rtl/slice_outstage.sv
// Output stage: a flop that can be bypassed.
// The flop loads d on each rising edge unless hold is high.
// Assumes reg_sel changes only during configuration.
module slice_outstage (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic reg_sel,
    input  logic d,
    output logic q
);
    logic flop_q;

    // Capture the path value when not held.
    always_ff @(posedge clk) begin
        if (!rst_n) flop_q <= 1'b0;
        else if (!hold) flop_q <= d;
    end

    // Select registered or direct path.
    always_comb begin
        q = reg_sel ? flop_q : d;
    end

    // Registered output lags the path by exactly one cycle.
    p_reg_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && reg_sel) |=> (!reg_sel || q == $past(d)));
endmodule

// File: rtl/cfg_slice.sv
// Top of the logic slice: two tables, a merge multiplexer and two output stages.
// Chain order from cfg_din: table A, then table B, then the control bits.
// A frame is therefore shifted in MSB first.
// Assumes that in merge mode the caller treats {x5, a_sel} as one 5-input vector.
module cfg_slice
    import slice_pkg::*;
#(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_din,
    input  logic [K-1:0] a_sel,
    input  logic [K-1:0] b_sel,
    input  logic         x5,
    input  logic         a_we,
    input  logic         a_wd,
    input  logic         b_we,
    input  logic         b_wd,
    output logic         out_a,
    output logic         out_b
);
    localparam int NOUT = 2;

    logic              chain_ab;
    logic              chain_bc;
    logic [CTRL_W-1:0] ctrl_q;
    logic              lut_a;
    logic              lut_b;
    logic [K-1:0]      addr_b;
    logic              merge;
    logic [NOUT-1:0]   path_d;
    logic [NOUT-1:0]   path_reg;
    logic [NOUT-1:0]   path_q;

    assign merge = ctrl_q[CTRL_MERGE];

    // Control bits at the end of the configuration chain.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (cfg_en) ctrl_q <= {ctrl_q[CTRL_W-2:0], chain_bc};
    end

    // Table B follows the A address when merged.
    always_comb begin
        addr_b = merge ? a_sel : b_sel;
    end

    slice_lut #(.K(K)) u_lut_a (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_din),
        .cfg_out(chain_ab), .addr(a_sel), .we(a_we), .wd(a_wd), .dout(lut_a)
    );

    slice_lut #(.K(K)) u_lut_b (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(chain_ab),
        .cfg_out(chain_bc), .addr(addr_b), .we(b_we), .wd(b_wd), .dout(lut_b)
    );

    // Combine tables: fifth input picks B over A when merged.
    always_comb begin
        path_d[0]   = (merge && x5) ? lut_b : lut_a;
        path_d[1]   = lut_b;
        path_reg[0] = ctrl_q[CTRL_REG_A];
        path_reg[1] = ctrl_q[CTRL_REG_B];
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        slice_outstage u_stage (
            .clk(clk), .rst_n(rst_n), .hold(cfg_en), .reg_sel(path_reg[g]),
            .d(path_d[g]), .q(path_q[g])
        );
    end

    assign out_a = path_q[0];
    assign out_b = path_q[1];
endmodule

// File: tb/cfg_slice_test.sv
module cfg_slice_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, cfg_din = 1'b0;
    logic [3:0] a_sel = '0, b_sel = '0;
    logic       x5 = 1'b0, a_we = 1'b0, a_wd = 1'b0, b_we = 1'b0, b_wd = 1'b0;
    logic       out_a, out_b;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    cfg_slice uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .a_sel(a_sel), .b_sel(b_sel), .x5(x5), .a_we(a_we), .a_wd(a_wd),
        .b_we(b_we), .b_wd(b_wd), .out_a(out_a), .out_b(out_b)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Frame: {merge, regB, regA, modeB, tB, modeA, tA}, MSB first (R2)
    function automatic logic [38:0] frame(input logic [2:0] ctl, input logic [1:0] mb,
                                          input logic [15:0] tb, input logic [1:0] ma,
                                          input logic [15:0] ta);
        return {ctl, mb, tb, ma, ta};
    endfunction

    task automatic load(input logic [38:0] fr);
        for (int i = 38; i >= 0; i--) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = fr[i];
        end
        @(negedge clk);
        cfg_en = 1'b0; cfg_din = 1'b0; a_we = 1'b0; b_we = 1'b0;
    endtask

    function automatic logic fn5(input int x);
        return ((x % 3) == 0) ^ x[4];
    endfunction

    initial begin
        logic [15:0] ta, tb, ram_exp;
        logic [31:0] hist;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset leaves both tables unconfigured, outputs zero
        for (int i = 0; i < 16; i++) begin
            a_sel = i[3:0]; b_sel = i[3:0]; #1;
            check("R1 out_a after reset", out_a, 1'b0);
            check("R1 out_b after reset", out_b, 1'b0);
        end

        // R2/R3: logic mode, both tables bypassed
        ta = 16'hA5C3; tb = 16'h1E69;
        load(frame(3'b000, 2'b01, tb, 2'b01, ta));
        for (int i = 0; i < 16; i++) begin
            a_sel = i[3:0]; b_sel = 4'(15 - i); #1;
            check("R2 R3 out_a logic", out_a, ta[i]);
            check("R2 R3 out_b logic", out_b, tb[15 - i]);
        end
        // R3: writes have no effect in logic mode
        @(negedge clk); a_sel = 4'd3; a_we = 1'b1; a_wd = ~ta[3];
        @(negedge clk); a_we = 1'b0; #1;
        check("R3 write ignored", out_a, ta[3]);

        // R6: merged 5-input function
        for (int i = 0; i < 16; i++) begin
            ta[i] = fn5(i); tb[i] = fn5(i + 16);
        end
        load(frame(3'b100, 2'b01, tb, 2'b01, ta));
        for (int x = 0; x < 32; x++) begin
            x5 = x[4]; a_sel = x[3:0]; b_sel = ~x[3:0]; #1;
            check("R6 merged out_a", out_a, fn5(x));
            check("R6 out_b uses a_sel", out_b, fn5(16 + (x % 16)));
        end
        x5 = 1'b0;

        // R7: registered output A, one-cycle latency
        ta = 16'h3C96;
        load(frame(3'b001, 2'b01, 16'h0, 2'b01, ta));
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); a_sel = i[3:0]; #1;
            if (i > 0) check("R7 holds before edge", out_a, ta[i - 1]);
            @(posedge clk); #1;
            check("R7 registered after edge", out_a, ta[i]);
        end

        // R4: memory mode write and asynchronous read
        load(frame(3'b000, 2'b00, 16'h0, 2'b10, 16'h0));
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); a_sel = i[3:0]; a_we = 1'b1; a_wd = ((i * 5) >> 2) & 1;
            ram_exp[i] = ((i * 5) >> 2) & 1;
        end
        @(negedge clk); a_we = 1'b0;
        for (int i = 0; i < 16; i++) begin
            a_sel = i[3:0]; #1;
            check("R4 memory readback", out_a, ram_exp[i]);
        end

        // R8: writes during configuration do not disturb the loaded content
        a_we = 1'b1; a_wd = 1'b1;
        load(frame(3'b000, 2'b00, 16'h0, 2'b10, 16'h0F0F));
        for (int i = 0; i < 16; i++) begin
            a_sel = i[3:0]; #1;
            check("R8 content equals frame", out_a, ((16'h0F0F >> i) & 1) != 0);
        end

        // R5: shift mode with tap selection
        load(frame(3'b000, 2'b00, 16'h0, 2'b11, 16'h0));
        hist = '0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); a_we = 1'b1; a_wd = ((k * 3) ^ (k >> 1)) & 1;
            hist = {hist[30:0], a_wd};
        end
        @(negedge clk); a_we = 1'b0;
        for (int j = 0; j < 16; j++) begin
            a_sel = j[3:0]; #1;
            check("R5 shift tap", out_a, hist[j]);
        end

        // R1: reset again clears loaded configuration
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 out_a after re-reset", out_a, 1'b0);
        check("R1 out_b after re-reset", out_b, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule